// File: doc/BRIEF.md
# Asynchronous Falling-Edge Event Capture

This block accepts a small set of event lines that arrive with no timing relation to the system clock. Each line goes through its own two-flop synchroniser. A falling edge on the synchronised level becomes a single-cycle event pulse for a downstream controller. Every line is registered before anything fans it out, so one asynchronous transition can never reach two flip-flops of the consumer's state with different values.

Two inputs can never be shown to fall at the same instant. The block therefore reports only proximity. A coincidence pulse fires when an input's edge lands in the same cycle as another input's edge, or within a programmed window of one or two clocks after it. A registered mask then records which inputs took part.

An optional qualifier input can be built in. When it is present and low, no events are accepted. The edge history keeps following the lines during that time, so an edge that falls while the qualifier is low is not delivered later.

Top module: `evt_capture_top`

## Requirements
- R1: Each input passes through two synchroniser flops before edge detection. An input first sampled low at clock edge k, after being sampled high at edge k-1, raises its event pulse in the cycle that follows edge k+1.
- R2: Synchronous active-high reset loads every synchroniser and history flop with 1 and clears the coincidence mask. In the cycle after a reset edge, no event pulse and no coincidence pulse are present.
- R3: Bit i of `evt_pulse` belongs to input line i, with bit 0 for line 0. It is raised only for a 1-to-0 transition of the synchronised input. A rising transition gives no pulse.
- R4: An event pulse lasts exactly one clock cycle and never waits for the consumer to clear it. Each input produces its pulses independently of the others.
- R5: `coin_pulse` is high in the cycle of an event pulse on some input when another input pulses in the same cycle or pulsed within the previous WIN cycles. It stays low when the two pulses are more than WIN cycles apart.
- R6: When the block is built with the qualifier (USE_QUAL=1) and `stable_in` is low, no event pulse is produced. The history keeps tracking, so an edge suppressed this way produces no pulse when `stable_in` returns high.
- R7: `coin_set` is loaded one cycle after `coin_pulse`. Bit i is set when input i pulsed in that cycle or within the previous WIN cycles, so at least two bits are set. Without a coincidence, the mask holds its value.
- R8: The parameter WIN selects a coincidence window of 1 or 2 clocks. Each input keeps its own countdown, which is reloaded whenever that input has an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_in | input | N_IN | Asynchronous event lines, idle high |
| stable_in | input | 1 | Qualifier, synchronous to clk; high means the lines may be sampled |
| evt_pulse | output | N_IN | One-cycle pulse per line on a falling edge |
| coin_pulse | output | 1 | Two or more lines fell within the window |
| coin_set | output | N_IN | Lines that took part in the latest coincidence |

## Verification
The bench builds the block with four inputs, WIN=2 and the qualifier present. This keeps the input space small enough to sweep every ordered pair of inputs at edge spacings of zero to four cycles. The sweep covers both sides of the window boundary for every pair, with the expected pulse cycles and masks derived from the latency arithmetic. A three-way simultaneous fall, rising edges and a qualifier-suppressed edge are then checked against the same model.

// File: rtl/evt_pkg.sv
package evt_pkg;

  // 1-to-0 transition between the delayed copy and the current level
  function automatic logic fell(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  // bits needed to hold a countdown that starts at win
  function automatic int unsigned cnt_width(input int unsigned win);
    return (win < 2) ? 1 : $clog2(win + 1);
  endfunction

  // set of live inputs other than position idx
  function automatic logic others_live(input logic [31:0] live, input int idx);
    logic [31:0] m;
    m = live;
    m[idx] = 1'b0;
    return |m;
  endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] d_async,
  output logic [N_IN-1:0] q_sync
);
  for (genvar g = 0; g < N_IN; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], d_async[g]};
    end
    assign q_sync[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/evt_edge.sv
module evt_edge
  import evt_pkg::*;
#(
  parameter int unsigned N_IN     = 4,
  parameter bit          USE_QUAL = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] sync_q,
  input  logic            stable_in,
  output logic [N_IN-1:0] hist_q,
  output logic [N_IN-1:0] fall
);
  logic qual_ok;

  if (USE_QUAL) begin : g_qual
    assign qual_ok = stable_in;
  end else begin : g_noqual
    logic unused_stable;
    assign unused_stable = stable_in;
    assign qual_ok = 1'b1;
  end

  // history follows the synchronised level regardless of the qualifier
  always_ff @(posedge clk) begin
    if (rst) hist_q <= '1;
    else     hist_q <= sync_q;
  end

  always_comb begin
    for (int i = 0; i < int'(N_IN); i++)
      fall[i] = fell(hist_q[i], sync_q[i]) & qual_ok;
  end
endmodule

// File: rtl/evt_coin.sv
module evt_coin
  import evt_pkg::*;
#(
  parameter int unsigned N_IN = 4,
  parameter int unsigned WIN  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] fall,
  output logic            coin,
  output logic [N_IN-1:0] live,
  output logic [N_IN-1:0] coin_set
);
  localparam int unsigned CW = cnt_width(WIN);
  localparam logic [CW-1:0] RELOAD = CW'(WIN);

  for (genvar g = 0; g < N_IN; g++) begin : g_cnt
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst)               cnt <= '0;
      else if (fall[g])      cnt <= RELOAD;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
    end
    assign live[g] = fall[g] | (cnt != '0);
  end

  always_comb begin
    logic [31:0] lv;
    lv = 32'(live);
    coin = 1'b0;
    for (int i = 0; i < int'(N_IN); i++)
      coin = coin | (fall[i] & others_live(lv, i));
  end

  always_ff @(posedge clk) begin
    if (rst)       coin_set <= '0;
    else if (coin) coin_set <= live;
  end
endmodule

// File: rtl/evt_capture_top.sv
module evt_capture_top #(
  parameter int unsigned N_IN     = 4,
  parameter int unsigned WIN      = 2,
  parameter bit          USE_QUAL = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] evt_in,
  input  logic            stable_in,
  output logic [N_IN-1:0] evt_pulse,
  output logic            coin_pulse,
  output logic [N_IN-1:0] coin_set
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [N_IN-1:0] sync_q;
  logic [N_IN-1:0] hist_q;
  logic [N_IN-1:0] fall;
  logic [N_IN-1:0] live;
  logic            coin;

  evt_sync #(.N_IN(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(evt_in), .q_sync(sync_q)
  );

  evt_edge #(.N_IN(N_IN), .USE_QUAL(USE_QUAL)) u_edge (
    .clk(clk), .rst(rst), .sync_q(sync_q), .stable_in(stable_in),
    .hist_q(hist_q), .fall(fall)
  );

  evt_coin #(.N_IN(N_IN), .WIN(WIN)) u_coin (
    .clk(clk), .rst(rst), .fall(fall), .coin(coin),
    .live(live), .coin_set(coin_set)
  );

  assign evt_pulse  = fall;
  assign coin_pulse = coin;
endmodule

// File: rtl/evt_capture_chk.sv
module evt_capture_chk #(
  parameter int unsigned N_IN     = 4,
  parameter bit          USE_QUAL = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic [N_IN-1:0] evt_in,
  input logic            stable_in,
  input logic [N_IN-1:0] evt_pulse,
  input logic            coin_pulse,
  input logic [N_IN-1:0] coin_set
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (evt_pulse == '0 && !coin_pulse && coin_set == '0)); // R2

  AST_PULSE_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
    (evt_pulse != '0) |-> ((evt_pulse & $past(evt_in, 2)) == '0)); // R1

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (evt_pulse != '0) |=> ((evt_pulse & $past(evt_pulse)) == '0)); // R4

  AST_QUAL_GATES: assert property (@(posedge clk) disable iff (rst)
    (USE_QUAL && !stable_in) |-> (evt_pulse == '0)); // R6

  AST_COIN_HAS_EVENT: assert property (@(posedge clk) disable iff (rst)
    coin_pulse |-> ($countones(evt_pulse) >= 1)); // R5

  AST_COIN_SET_MULTI: assert property (@(posedge clk) disable iff (rst)
    coin_pulse |=> ($countones(coin_set) >= 2)); // R7

  AST_COIN_SET_HOLD: assert property (@(posedge clk) disable iff (rst)
    !coin_pulse |=> $stable(coin_set)); // R7
endmodule

bind evt_capture_top evt_capture_chk #(.N_IN(N_IN), .USE_QUAL(USE_QUAL)) u_chk (
  .clk(clk), .rst(rst), .evt_in(evt_in), .stable_in(stable_in),
  .evt_pulse(evt_pulse), .coin_pulse(coin_pulse), .coin_set(coin_set)
);

// File: tb/evt_capture_top_test.sv
module evt_capture_top_test;
  localparam int CLK_P = 10;
  localparam int N     = 4;
  localparam int W     = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] evt_in = '1;
  logic         stable_in = 1'b1;
  logic [N-1:0] evt_pulse;
  logic         coin_pulse;
  logic [N-1:0] coin_set;

  int n_run  = 0;
  int n_fail = 0;
  logic [N-1:0] exp_set = '0;

  evt_capture_top #(.N_IN(N), .WIN(W), .USE_QUAL(1'b1)) uut (
    .clk(clk), .rst(rst), .evt_in(evt_in), .stable_in(stable_in),
    .evt_pulse(evt_pulse), .coin_pulse(coin_pulse), .coin_set(coin_set)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // reset with idle-high inputs
    repeat (3) step();
    rst = 1'b0;
    for (int t = 0; t < 4; t++) begin
      step();
      chk("R2 pulses after reset", 32'(evt_pulse), 0);
      chk("R2 coin after reset", 32'(coin_pulse), 0);
      chk("R2 mask after reset", 32'(coin_set), 0);
    end

    // pair sweep: line a falls at t=0, line b at t=d
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        if (a == b) continue;
        for (int d = 0; d <= 4; d++) begin
          for (int t = 0; t <= d + 5; t++) begin
            logic [N-1:0] ep;
            logic         ec;
            ep = '0;
            if (t == 2)     ep[a] = 1'b1;
            if (t == d + 2) ep[b] = 1'b1;
            ec = (t == d + 2) && (d <= W);
            if (t == d + 3 && d <= W) begin
              exp_set = '0;
              exp_set[a] = 1'b1;
              exp_set[b] = 1'b1;
            end
            chk("R1 R3 R4 pulse timing", 32'(evt_pulse), 32'(ep));
            chk((d <= W) ? "R5 R8 coin inside window" : "R5 R8 coin outside window",
                32'(coin_pulse), 32'(ec));
            chk("R7 coincidence mask", 32'(coin_set), 32'(exp_set));
            if (t == 0) evt_in[a] = 1'b0;
            if (t == d) evt_in[b] = 1'b0;
            step();
          end
          evt_in = '1;
          for (int t = 0; t < 5; t++) begin
            step();
            chk("R3 rising edge gives no pulse", 32'(evt_pulse), 0);
          end
        end
      end
    end

    // three lines fall together
    evt_in = 4'b1000;
    step(); step();
    chk("R4 three lines pulse together", 32'(evt_pulse), 32'h7);
    chk("R5 three-way coincidence", 32'(coin_pulse), 1);
    step();
    chk("R7 three-way mask", 32'(coin_set), 32'h7);
    chk("R4 pulse lasts one cycle", 32'(evt_pulse), 0);
    evt_in = '1;
    repeat (5) step();

    // qualifier low hides the edge, no stale pulse on return
    stable_in = 1'b0;
    evt_in[3] = 1'b0;
    for (int t = 0; t < 5; t++) begin
      step();
      chk("R6 qualifier suppresses", 32'(evt_pulse), 0);
    end
    stable_in = 1'b1;
    for (int t = 0; t < 4; t++) begin
      step();
      chk("R6 no stale pulse", 32'(evt_pulse), 0);
    end
    evt_in = '1;
    repeat (4) step();
    evt_in[3] = 1'b0;
    step(); step();
    chk("R6 qualified edge accepted", 32'(evt_pulse), 32'h8);
    evt_in = '1;
    repeat (4) step();

    // reset clears the mask
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R2 reset clears mask", 32'(coin_set), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule